// File: doc/BRIEF.md
# Timebase Tap Watchdog Timer

This block is a watchdog built on a free-running 64-bit timebase counter. A 6-bit period select picks one bit of that counter. Each time the chosen bit goes from 0 to 1, a watchdog event occurs. Choosing bit index `63 - period` makes the event interval 2^(64-period) timebase ticks. A smaller period select therefore gives a slower watchdog, and a select of zero watches the top bit.

Events that software does not service move the block through three levels. The first event arms it. The second sets an interrupt flag, which drives the interrupt line when interrupts are enabled. The third asks for a chip reset by driving a one-cycle pulse, and it records the reset-control code that was in force. Software keeps the watchdog quiet by writing ones to the arm and interrupt flags in the status word. The reset-control code can be written once: after it holds a non-zero value it cannot be changed.

Software reaches the block through a small register port. Writes are synchronous. Reads are combinational and cover the control word, the status word and the two halves of the timebase.

Top module: `wdg_tap_watchdog`

## Requirements
- R1: After reset, the control word, the status word, both timebase words, `irq` and `rst_req` all read 0.
- R2: The control word is at address 0. It holds the period select, with bits [1:0] in word bits 31:30 and bits [5:2] in word bits 20:17, the reset-control code in bits 29:28 and the interrupt enable in bit 27. All other bits read 0.
- R3: The timebase goes up by one on every clock in which `count_en` is high, and holds its value otherwise. Its low word reads at address 2 and its high word at address 3.
- R4: An event is a 0-to-1 change of timebase bit `63 - psel`. The first unserviced event sets the arm flag, status bit 31, in the clock after the timebase reaches the value at which that bit rises. Events recur every 2^(64-psel) ticks.
- R5: The next event that finds the arm flag set raises the interrupt flag, status bit 30. `irq` is high exactly while that flag and the interrupt enable are both set.
- R6: The next event that finds both flags set, with a non-zero reset-control code, drives `rst_req` high for exactly one cycle and copies the code into status bits 29:28.
- R7: While status bits 29:28 are non-zero, events change nothing. After software clears those bits by writing ones, escalation resumes.
- R8: The status word is at address 1. A one written to a status bit clears that bit, and a zero leaves it unchanged. Clearing bits 31 and 30 makes escalation start again from the first level.
- R9: Once the reset-control code is non-zero, later control writes leave it unchanged while still updating the period select and the interrupt enable.
- R10: When the reset-control code is 0, an event that finds both flags set drives no `rst_req` and leaves status bits 29:28 at 0.
- R11: When the interrupt enable is 0, the interrupt flag still sets but `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_en | input | 1 | Timebase count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Watchdog interrupt, level |
| rst_req | output | 1 | One-cycle reset request pulse |

## Verification
An edge counted with `count_en` high leaves the timebase equal to the number of enabled edges so far. The bench keeps that count itself. A tap event is present while the timebase holds an odd multiple of 2^k, where k = 63 - psel. The flag, the record field and the `rst_req` pulse that result all appear after the next edge, so they are due one count after that value. `irq` follows the flag in the same cycle. Register writes take effect at the edge that captures them. Every sample is taken 1 ns or more after a rising edge, and the expected values come from the count and the period alone.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;
   localparam int REG_AW = 2;

   localparam logic [REG_AW-1:0] A_CTRL = 2'd0;
   localparam logic [REG_AW-1:0] A_STAT = 2'd1;
   localparam logic [REG_AW-1:0] A_TBLO = 2'd2;
   localparam logic [REG_AW-1:0] A_TBHI = 2'd3;

   // control word field positions
   localparam int C_PSL_HI = 31;
   localparam int C_PSL_LO = 30;
   localparam int C_RC_HI  = 29;
   localparam int C_RC_LO  = 28;
   localparam int C_IE     = 27;
   localparam int C_PSU_HI = 20;
   localparam int C_PSU_LO = 17;

   // status word field positions
   localparam int S_ARM    = 31;
   localparam int S_INT    = 30;
   localparam int S_REC_HI = 29;
   localparam int S_REC_LO = 28;
endpackage

// File: rtl/wdg_ctrl_reg.sv
`timescale 1ns/1ps
module wdg_ctrl_reg #(
   parameter int PSEL_W = 6,
   parameter int RC_W   = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [PSEL_W-1:0] psel_in,
   input  logic              ie_in,
   input  logic [RC_W-1:0]   rc_in,
   output logic [PSEL_W-1:0] psel,
   output logic              irq_en,
   output logic [RC_W-1:0]   rc
);
   logic [PSEL_W-1:0] psel_q;
   logic              ie_q;
   logic [RC_W-1:0]   rc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psel_q <= '0;
         ie_q   <= 1'b0;
         rc_q   <= '0;
      end else if (wr_stb) begin
         psel_q <= psel_in;
         ie_q   <= ie_in;
         // write-once: the code locks after its first non-zero value
         if (rc_q == '0) rc_q <= rc_in;
      end
   end

   assign psel   = psel_q;
   assign irq_en = ie_q;
   assign rc     = rc_q;
endmodule

// File: rtl/wdg_timebase.sv
`timescale 1ns/1ps
module wdg_timebase #(
   parameter int TB_W   = 64,
   parameter int PSEL_W = 6
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              count_en,
   input  logic [PSEL_W-1:0] psel,
   output logic [TB_W-1:0]   tb,
   output logic              tap_rise
);
   localparam logic [PSEL_W-1:0] TOP_IDX = PSEL_W'(TB_W - 1);

   logic [TB_W-1:0]   tb_q;
   logic              tap_q;
   logic [PSEL_W-1:0] tap_idx;
   logic              tap_now;

   always_comb begin
      tap_idx = TOP_IDX - psel;
      tap_now = tb_q[tap_idx];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tb_q  <= '0;
         tap_q <= 1'b0;
      end else begin
         if (count_en) tb_q <= tb_q + TB_W'(1);
         tap_q <= tap_now;
      end
   end

   assign tb       = tb_q;
   assign tap_rise = tap_now & ~tap_q;
endmodule

// File: rtl/wdg_escalate.sv
`timescale 1ns/1ps
module wdg_escalate #(
   parameter int RC_W = 2
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tap_rise,
   input  logic            clr_arm,
   input  logic            clr_int,
   input  logic [RC_W-1:0] clr_rec,
   input  logic [RC_W-1:0] rc,
   output logic            arm_flag,
   output logic            int_flag,
   output logic [RC_W-1:0] rec,
   output logic            rst_pulse
);
   logic            arm_q, int_q, pulse_q;
   logic [RC_W-1:0] rec_q;
   logic            arm_d, int_d, pulse_d;
   logic [RC_W-1:0] rec_d;
   logic            step;

   always_comb begin
      step    = tap_rise & ~(|rec_q);
      arm_d   = arm_q & ~clr_arm;
      int_d   = int_q & ~clr_int;
      rec_d   = rec_q & ~clr_rec;
      pulse_d = 1'b0;
      if (step) begin
         if (!arm_q) begin
            arm_d = 1'b1;
         end else if (!int_q) begin
            int_d = 1'b1;
         end else if (rc != '0) begin
            rec_d   = rc;
            pulse_d = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q   <= 1'b0;
         int_q   <= 1'b0;
         rec_q   <= '0;
         pulse_q <= 1'b0;
      end else begin
         arm_q   <= arm_d;
         int_q   <= int_d;
         rec_q   <= rec_d;
         pulse_q <= pulse_d;
      end
   end

   assign arm_flag  = arm_q;
   assign int_flag  = int_q;
   assign rec       = rec_q;
   assign rst_pulse = pulse_q;
endmodule

// File: rtl/wdg_tap_watchdog.sv
`timescale 1ns/1ps
module wdg_tap_watchdog
   import wdg_pkg::*;
#(
   parameter int TB_W   = 64,
   parameter int PSEL_W = 6,
   parameter int RC_W   = 2,
   parameter int DATA_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              count_en,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [REG_AW-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq,
   output logic              rst_req
);
   // elaboration-time parameter checks
   if (TB_W != (1 << PSEL_W)) begin : g_bad_tb
      $error("TB_W must equal 2**PSEL_W");
   end
   if (PSEL_W != 6 || RC_W != 2 || DATA_W != 32) begin : g_bad_layout
      $error("register layout needs PSEL_W=6, RC_W=2, DATA_W=32");
   end

   logic [PSEL_W-1:0] psel_val;
   logic              ie_val;
   logic [RC_W-1:0]   rc_val;
   logic [TB_W-1:0]   tb_val;
   logic              tap_rise;
   logic              arm_flag, int_flag;
   logic [RC_W-1:0]   rec_val;
   logic              ctrl_wr, stat_wr;
   logic [DATA_W-1:0] tb_lo, tb_hi;
   logic              wr_data_unused;

   assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
   assign stat_wr = wr_en && (wr_addr == A_STAT);
   assign wr_data_unused = ^{wr_data[26:21], wr_data[16:0]};

   wdg_ctrl_reg #(.PSEL_W(PSEL_W), .RC_W(RC_W)) ctrl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (ctrl_wr),
      .psel_in ({wr_data[C_PSU_HI:C_PSU_LO], wr_data[C_PSL_HI:C_PSL_LO]}),
      .ie_in   (wr_data[C_IE]),
      .rc_in   (wr_data[C_RC_HI:C_RC_LO]),
      .psel    (psel_val),
      .irq_en  (ie_val),
      .rc      (rc_val)
   );

   wdg_timebase #(.TB_W(TB_W), .PSEL_W(PSEL_W)) tbase_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .count_en (count_en),
      .psel     (psel_val),
      .tb       (tb_val),
      .tap_rise (tap_rise)
   );

   wdg_escalate #(.RC_W(RC_W)) esc_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tap_rise  (tap_rise),
      .clr_arm   (stat_wr & wr_data[S_ARM]),
      .clr_int   (stat_wr & wr_data[S_INT]),
      .clr_rec   ({RC_W{stat_wr}} & wr_data[S_REC_HI:S_REC_LO]),
      .rc        (rc_val),
      .arm_flag  (arm_flag),
      .int_flag  (int_flag),
      .rec       (rec_val),
      .rst_pulse (rst_req)
   );

   assign irq = int_flag & ie_val;

   if (TB_W > DATA_W) begin : g_tb_split
      assign tb_lo = DATA_W'(tb_val);
      assign tb_hi = DATA_W'(tb_val >> DATA_W);
   end else begin : g_tb_single
      assign tb_lo = DATA_W'(tb_val);
      assign tb_hi = '0;
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_CTRL: begin
            rd_data[C_PSL_HI:C_PSL_LO] = psel_val[1:0];
            rd_data[C_PSU_HI:C_PSU_LO] = psel_val[5:2];
            rd_data[C_RC_HI:C_RC_LO]   = rc_val;
            rd_data[C_IE]              = ie_val;
         end
         A_STAT: begin
            rd_data[S_ARM]             = arm_flag;
            rd_data[S_INT]             = int_flag;
            rd_data[S_REC_HI:S_REC_LO] = rec_val;
         end
         A_TBLO:  rd_data = tb_lo;
         default: rd_data = tb_hi;
      endcase
   end
endmodule

// File: rtl/wdg_tap_watchdog_chk.sv
`timescale 1ns/1ps
module wdg_tap_watchdog_chk #(
   parameter int TB_W = 64,
   parameter int RC_W = 2
)(
   input logic            clk,
   input logic            rst_n,
   input logic            count_en,
   input logic [TB_W-1:0] tb,
   input logic            arm_flag,
   input logic            int_flag,
   input logic            rst_req,
   input logic [RC_W-1:0] rec,
   input logic [RC_W-1:0] rc
);
   assert_tb_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && count_en) |=> (tb == $past(tb) + TB_W'(1)));

   assert_tb_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && !count_en) |=> $stable(tb));

   assert_int_after_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_flag) |-> $past(arm_flag));

   assert_rst_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   assert_rst_after_int_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> ($past(int_flag) && rec != '0));

   assert_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rec != '0) |=> !rst_req);

   assert_rc_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rc != '0) |=> (rc == $past(rc)));
endmodule

bind wdg_tap_watchdog wdg_tap_watchdog_chk #(.TB_W(TB_W), .RC_W(RC_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .count_en (count_en),
   .tb       (tb_val),
   .arm_flag (arm_flag),
   .int_flag (int_flag),
   .rst_req  (rst_req),
   .rec      (rec_val),
   .rc       (rc_val)
);

// File: tb/wdg_tap_watchdog_tb_top.sv
`timescale 1ns/1ps
module wdg_tap_watchdog_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        count_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        irq, rst_req;

   int n_checks = 0;
   int n_fail = 0;
   int cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdg_tap_watchdog dut_i (
      .clk(clk), .rst_n(rst_n), .count_en(count_en),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .irq(irq), .rst_req(rst_req)
   );

   task automatic chk_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at count %0d: actual=%0h expected=%0h", req, cyc, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
      if (count_en) cyc++;
   endtask

   task automatic do_reset();
      count_en = 1'b0;
      wr_en = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      rst_n = 1'b1;
      cyc = 0;
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
      wr_addr = a;
      wr_data = d;
      wr_en = 1'b1;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   function automatic logic [31:0] make_ctrl(input logic [5:0] ps, input logic ie, input logic [1:0] rc);
      logic [31:0] w;
      w = '0;
      w[31:30] = ps[1:0];
      w[20:17] = ps[5:2];
      w[29:28] = rc;
      w[27]    = ie;
      return w;
   endfunction

   task automatic run_to(input int target);
      while (cyc < target) tick();
   endtask

   // full escalation sweep for one period select
   task automatic sweep(input int p);
      int k, lo, per, arm_at, int_at, rst_at, last;
      logic [1:0]  rc;
      logic [31:0] s, t;
      k = 63 - p;
      lo = 1 << k;
      per = 2 * lo;
      arm_at = lo + 1;
      int_at = lo + per + 1;
      rst_at = lo + 2 * per + 1;
      last = rst_at + 2 * per + 1;
      rc = 2'((p % 3) + 1);
      do_reset();
      wr_reg(2'd0, make_ctrl(6'(p), 1'b1, rc));
      count_en = 1'b1;
      while (cyc < last) begin
         tick();
         rd_reg(2'd1, s);
         rd_reg(2'd2, t);
         chk_eq("R3 timebase low", t, 64'(cyc));
         chk_eq("R4 arm flag", s[31], cyc >= arm_at);
         chk_eq("R5 int flag", s[30], cyc >= int_at);
         chk_eq("R5 irq", irq, cyc >= int_at);
         chk_eq("R6/R7 rst_req", rst_req, cyc == rst_at);
         chk_eq("R6/R7 record", s[29:28], (cyc >= rst_at) ? rc : 2'd0);
      end
      count_en = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v;

      // R1 reset state
      do_reset();
      for (int a = 0; a < 4; a++) begin
         rd_reg(2'(a), v);
         chk_eq("R1 register after reset", v, 0);
      end
      chk_eq("R1 irq", irq, 0);
      chk_eq("R1 rst_req", rst_req, 0);

      // R3 timebase holds while disabled
      repeat (5) tick();
      rd_reg(2'd2, v);
      chk_eq("R3 hold while disabled", v, 0);

      // R2 layout and R9 lock
      wr_reg(2'd0, 32'hFFFF_FFFF);
      rd_reg(2'd0, v);
      chk_eq("R2 control readback", v, 32'hF81E_0000);
      wr_reg(2'd0, make_ctrl(6'b101101, 1'b0, 2'b01));
      rd_reg(2'd0, v);
      chk_eq("R9 code locked, others updated", v, make_ctrl(6'b101101, 1'b0, 2'b11));
      rd_reg(2'd3, v);
      chk_eq("R3 high word", v, 0);

      // R3 high word carries over after 2^32 is impractical; counting low word instead
      count_en = 1'b1;
      repeat (7) tick();
      count_en = 1'b0;
      rd_reg(2'd2, v);
      chk_eq("R3 count of enabled edges", v, 7);
      tick();
      rd_reg(2'd2, v);
      chk_eq("R3 hold after disable", v, 7);

      // R4 R5 R6 R7 sweep over several period selects
      for (int p = 63; p >= 59; p--) sweep(p);

      // R10 R11: no reset code, interrupt disabled
      do_reset();
      wr_reg(2'd0, make_ctrl(6'd63, 1'b0, 2'b00));
      count_en = 1'b1;
      while (cyc < 14) begin
         tick();
         rd_reg(2'd1, v);
         chk_eq("R11 int flag sets", v[30], cyc >= 4);
         chk_eq("R11 irq masked", irq, 0);
         chk_eq("R10 no rst_req", rst_req, 0);
         chk_eq("R10 record stays zero", v[29:28], 0);
      end
      count_en = 1'b0;

      // R8 service and R7 resume
      do_reset();
      wr_reg(2'd0, make_ctrl(6'd60, 1'b1, 2'b01));
      count_en = 1'b1;
      run_to(25);
      rd_reg(2'd1, v);
      chk_eq("R8 both flags before service", v, 32'hC000_0000);
      wr_reg(2'd1, 32'h0000_0000);
      rd_reg(2'd1, v);
      chk_eq("R8 zero write ignored", v, 32'hC000_0000);
      chk_eq("R8 irq still high", irq, 1);
      wr_reg(2'd1, 32'hC000_0000);
      rd_reg(2'd1, v);
      chk_eq("R8 flags cleared", v, 0);
      chk_eq("R8 irq dropped", irq, 0);
      run_to(40);
      rd_reg(2'd1, v);
      chk_eq("R8 no flag before next event", v, 0);
      tick();
      rd_reg(2'd1, v);
      chk_eq("R8 restart arms first", v, 32'h8000_0000);
      run_to(57);
      rd_reg(2'd1, v);
      chk_eq("R8 second level", v, 32'hC000_0000);
      run_to(72);
      chk_eq("R6 no early pulse", rst_req, 0);
      tick();
      rd_reg(2'd1, v);
      chk_eq("R6 pulse after service cycle", rst_req, 1);
      chk_eq("R6 record", v, 32'hD000_0000);
      tick();
      chk_eq("R6 pulse one cycle", rst_req, 0);
      wr_reg(2'd1, 32'h3000_0000);
      rd_reg(2'd1, v);
      chk_eq("R7 record cleared, flags kept", v, 32'hC000_0000);
      run_to(88);
      chk_eq("R7 no pulse yet", rst_req, 0);
      tick();
      chk_eq("R7 resumes after record clear", rst_req, 1);
      count_en = 1'b0;

      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule